// File: doc/BRIEF.md
# USB Device Address Assignment Controller

This block sits on the device side of a USB link, behind a receive front end that has already split each incoming packet into its PID byte, its token fields and its payload bytes. It follows the enumeration sequence that gives the device its bus address. First it finds a SETUP token aimed at the default address and endpoint 0. It then collects the 8-byte setup data stage, requests an ACK handshake for a well-formed data stage, and waits for the zero-length IN status stage to complete. Only then does it switch to the new address.

The front end shows the PID byte on `rx_pid_vld`. Token fields, already checked against their 5-bit CRC, follow on `rx_tok_vld`. Payload bytes without their CRC come on `rx_byte_vld`. A separate `rx_eop` cycle after the last byte carries the 16-bit CRC verdict on `rx_crc_ok`. The block returns the address to compare tokens against, a flag that says a non-default address is in force, and two one-cycle request pulses. One tells the transmitter to send an ACK. The other tells it to answer the status IN with a zero-length data packet.

Top module: `usb_addr_assign`

## Requirements
- R1: After reset, dev_addr is 0 and addr_valid, ack_req and status_req are all 0.
- R2: A PID byte counts only when its upper nibble is the bitwise inverse of its lower nibble. The lower nibble is the type: SETUP 4'b1101 (byte 0x2D), IN 4'b1001 (0x69), DATA0 4'b0011 (0xC3), ACK 4'b0010 (0xD2). Any other byte has no effect on the flow.
- R3: A SETUP token starts the flow only if its address field is 7'd0 and its endpoint is 0. A SETUP to any other address produces no ack_req.
- R4: After a matched SETUP, a DATA0 packet of exactly 8 payload bytes whose end arrives with rx_crc_ok high makes ack_req high for exactly one cycle. That cycle is the one after the rx_eop cycle.
- R5: A data stage with a byte count other than 8, or with rx_crc_ok low at rx_eop, gives no ack_req and leaves dev_addr unchanged.
- R6: The data stage is an address request only when byte 0 is 0x00 and byte 1 is 0x05. The requested address is bits 6:0 of byte 2. Any other well-formed data stage is still ACKed but changes no address, and no status stage follows it.
- R7: The requested address is not applied during the data stage. An IN token to address 0, endpoint 0, must come first. status_req pulses in the cycle after that token, and dev_addr stays 0 until the host's ACK.
- R8: An ACK PID after status_req loads dev_addr with the requested address in the next cycle. addr_valid then equals (dev_addr != 0).
- R9: While addr_valid is high, a SETUP to address 0 is ignored: no ack_req and no address change.
- R10: Any valid PID other than DATA0 in place of the data stage abandons the flow without ack_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pid_vld | input | 1 | PID byte present this cycle |
| rx_pid | input | 8 | PID byte: check nibble [7:4], type nibble [3:0] |
| rx_tok_vld | input | 1 | Token fields present this cycle (token CRC already good) |
| rx_tok_addr | input | 7 | Token address field |
| rx_tok_endp | input | 4 | Token endpoint field |
| rx_byte_vld | input | 1 | Payload byte present this cycle |
| rx_byte | input | 8 | Payload byte |
| rx_eop | input | 1 | End of the current packet |
| rx_crc_ok | input | 1 | Data CRC verdict, valid with rx_eop |
| dev_addr | output | 7 | Address the device currently answers at |
| addr_valid | output | 1 | A non-default address is in force |
| ack_req | output | 1 | One-cycle request to send an ACK handshake |
| status_req | output | 1 | One-cycle request to send a zero-length DATA reply |

## Verification
The checker watches several rules on every cycle. Each handshake request must be a single-cycle pulse caused by the input event one cycle earlier: an end of packet with a good CRC for ack_req, a token to address 0 for status_req. The address may change only right after an ACK PID. addr_valid must never stand with a zero address, and no ACK may be requested once the device is addressed. Other rules are shown only by the bench's scenarios. These are the exact 8-byte length, the decode of the request bytes and of byte 2's low seven bits, the rejection of badly checked PIDs, of non-default SETUP targets and of DATA1, and the rule that an ACKed request other than an address request leaves the address alone.

// File: rtl/usb_addr_pkg.sv
package usb_addr_pkg;

  localparam int ADDR_W    = 7;
  localparam int ENDP_W    = 4;
  localparam int SETUP_LEN = 8;

  localparam logic [3:0] PT_SETUP = 4'b1101;
  localparam logic [3:0] PT_IN    = 4'b1001;
  localparam logic [3:0] PT_DATA0 = 4'b0011;
  localparam logic [3:0] PT_ACK   = 4'b0010;

  localparam logic [7:0] REQ_TYPE_STD_OUT = 8'h00;
  localparam logic [7:0] REQ_CODE_SETADDR = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP_TOK,
    ST_DATA_PID,
    ST_DATA,
    ST_STAT_IN,
    ST_STAT_TOK,
    ST_STAT_ACK
  } flow_state_e;

  function automatic logic pid_is_sane(input logic [7:0] p);
    return p[7:4] == ~p[3:0];
  endfunction

  function automatic logic is_addr_request(input logic [7:0] b0, input logic [7:0] b1);
    return (b0 == REQ_TYPE_STD_OUT) && (b1 == REQ_CODE_SETADDR);
  endfunction

endpackage

// File: rtl/usb_pid_decode.sv
module usb_pid_decode
  import usb_addr_pkg::*;
(
  input  logic       pid_vld,
  input  logic [7:0] pid,
  output logic       hit_setup,
  output logic       hit_in,
  output logic       hit_data0,
  output logic       hit_ack,
  output logic       hit_any
);

  logic sane;
  assign sane      = pid_vld && pid_is_sane(pid);
  assign hit_any   = sane;
  assign hit_setup = sane && (pid[3:0] == PT_SETUP);
  assign hit_in    = sane && (pid[3:0] == PT_IN);
  assign hit_data0 = sane && (pid[3:0] == PT_DATA0);
  assign hit_ack   = sane && (pid[3:0] == PT_ACK);

endmodule

// File: rtl/usb_setup_collect.sv
module usb_setup_collect
  import usb_addr_pkg::*;
#(
  parameter int LEN = SETUP_LEN,
  parameter int AW  = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          cap_en,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  output logic          len_exact,
  output logic          req_is_addr,
  output logic [AW-1:0] req_addr
);

  localparam int CW = $clog2(LEN + 2);
  localparam logic [CW-1:0] CNT_FULL = CW'(LEN);
  localparam logic [CW-1:0] CNT_OVER = CW'(LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [7:0]    b0_q, b1_q;
  logic [AW-1:0] b2_q;
  logic          take;

  assign take = cap_en && byte_vld;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
      b0_q  <= '0;
      b1_q  <= '0;
      b2_q  <= '0;
    end else if (take) begin
      if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(0)) b0_q <= byte_in;
      if (cnt_q == CW'(1)) b1_q <= byte_in;
      if (cnt_q == CW'(2)) b2_q <= byte_in[AW-1:0];
    end
  end

  assign len_exact   = (cnt_q == CNT_FULL);
  assign req_is_addr = is_addr_request(b0_q, b1_q);
  assign req_addr    = b2_q;

endmodule

// File: rtl/usb_addr_fsm.sv
module usb_addr_fsm
  import usb_addr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int EW = ENDP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_setup,
  input  logic          hit_in,
  input  logic          hit_data0,
  input  logic          hit_ack,
  input  logic          hit_any,
  input  logic          tok_vld,
  input  logic [AW-1:0] tok_addr,
  input  logic [EW-1:0] tok_endp,
  input  logic          eop,
  input  logic          crc_ok,
  input  logic          len_exact,
  input  logic          req_is_addr,
  input  logic [AW-1:0] req_addr,
  output logic          col_clear,
  output logic          col_en,
  output logic          setup_match_evt,
  output logic          data_good_evt,
  output logic          status_evt,
  output logic          commit_evt,
  output logic [AW-1:0] dev_addr,
  output logic          addr_valid,
  output logic          ack_req,
  output logic          status_req
);

  flow_state_e   st_q, st_d;
  logic [AW-1:0] pend_q;
  logic          tok_default;

  assign tok_default = tok_vld && (tok_addr == '0) && (tok_endp == '0);

  always_comb begin
    st_d            = st_q;
    setup_match_evt = 1'b0;
    data_good_evt   = 1'b0;
    status_evt      = 1'b0;
    commit_evt      = 1'b0;
    col_clear       = 1'b0;
    if (hit_setup && !addr_valid) begin
      st_d = ST_SETUP_TOK;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = ST_IDLE;
        ST_SETUP_TOK: begin
          if (tok_vld) begin
            if (tok_default) begin
              st_d            = ST_DATA_PID;
              setup_match_evt = 1'b1;
            end else begin
              st_d = ST_IDLE;
            end
          end else if (hit_any) begin
            st_d = ST_IDLE;
          end
        end
        ST_DATA_PID: begin
          if (hit_data0) begin
            st_d      = ST_DATA;
            col_clear = 1'b1;
          end else if (hit_any) begin
            st_d = ST_IDLE;
          end
        end
        ST_DATA: begin
          if (eop) begin
            if (crc_ok && len_exact) begin
              data_good_evt = 1'b1;
              st_d          = req_is_addr ? ST_STAT_IN : ST_IDLE;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_STAT_IN: begin
          if (hit_in) st_d = ST_STAT_TOK;
        end
        ST_STAT_TOK: begin
          if (tok_vld) begin
            if (tok_default) begin
              status_evt = 1'b1;
              st_d       = ST_STAT_ACK;
            end else begin
              st_d = ST_STAT_IN;
            end
          end
        end
        ST_STAT_ACK: begin
          if (hit_ack) begin
            commit_evt = 1'b1;
            st_d       = ST_IDLE;
          end else if (hit_any) begin
            st_d = ST_STAT_IN;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign col_en = (st_q == ST_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pend_q     <= '0;
      dev_addr   <= '0;
      addr_valid <= 1'b0;
      ack_req    <= 1'b0;
      status_req <= 1'b0;
    end else begin
      st_q       <= st_d;
      ack_req    <= data_good_evt;
      status_req <= status_evt;
      if (data_good_evt && req_is_addr) pend_q <= req_addr;
      if (commit_evt) begin
        dev_addr   <= pend_q;
        addr_valid <= (pend_q != '0);
      end
    end
  end

endmodule

// File: rtl/usb_addr_assign.sv
module usb_addr_assign
  import usb_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pid_vld,
  input  logic [7:0]        rx_pid,
  input  logic              rx_tok_vld,
  input  logic [ADDR_W-1:0] rx_tok_addr,
  input  logic [ENDP_W-1:0] rx_tok_endp,
  input  logic              rx_byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic              rx_eop,
  input  logic              rx_crc_ok,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              addr_valid,
  output logic              ack_req,
  output logic              status_req
);

  logic hit_setup, hit_in, hit_data0, hit_ack, hit_any;
  logic col_clear, col_en, len_exact, req_is_addr;
  logic [ADDR_W-1:0] req_addr;
  logic setup_match_evt, data_good_evt, status_evt, commit_evt;

  usb_pid_decode u_pid (
    .pid_vld   (rx_pid_vld),
    .pid       (rx_pid),
    .hit_setup (hit_setup),
    .hit_in    (hit_in),
    .hit_data0 (hit_data0),
    .hit_ack   (hit_ack),
    .hit_any   (hit_any)
  );

  usb_setup_collect #(.LEN(SETUP_LEN), .AW(ADDR_W)) u_col (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (col_clear),
    .cap_en      (col_en),
    .byte_vld    (rx_byte_vld),
    .byte_in     (rx_byte),
    .len_exact   (len_exact),
    .req_is_addr (req_is_addr),
    .req_addr    (req_addr)
  );

  usb_addr_fsm #(.AW(ADDR_W), .EW(ENDP_W)) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .hit_setup       (hit_setup),
    .hit_in          (hit_in),
    .hit_data0       (hit_data0),
    .hit_ack         (hit_ack),
    .hit_any         (hit_any),
    .tok_vld         (rx_tok_vld),
    .tok_addr        (rx_tok_addr),
    .tok_endp        (rx_tok_endp),
    .eop             (rx_eop),
    .crc_ok          (rx_crc_ok),
    .len_exact       (len_exact),
    .req_is_addr     (req_is_addr),
    .req_addr        (req_addr),
    .col_clear       (col_clear),
    .col_en          (col_en),
    .setup_match_evt (setup_match_evt),
    .data_good_evt   (data_good_evt),
    .status_evt      (status_evt),
    .commit_evt      (commit_evt),
    .dev_addr        (dev_addr),
    .addr_valid      (addr_valid),
    .ack_req         (ack_req),
    .status_req      (status_req)
  );

endmodule

// File: rtl/usb_addr_assign_chk.sv
module usb_addr_assign_chk
  import usb_addr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_pid_vld,
  input logic [7:0]        rx_pid,
  input logic              rx_tok_vld,
  input logic [ADDR_W-1:0] rx_tok_addr,
  input logic              rx_eop,
  input logic              rx_crc_ok,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              addr_valid,
  input logic              ack_req,
  input logic              status_req,
  input logic              setup_match_evt,
  input logic              commit_evt
);

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);

  p_ack_after_good_eop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(rx_eop && rx_crc_ok));

  p_status_after_tok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_req |-> $past(rx_tok_vld && rx_tok_addr == '0));

  p_addr_moves_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_addr) |-> $past(rx_pid_vld && rx_pid == 8'hD2));

  p_valid_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> dev_addr != '0);

  p_quiet_when_addressed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !ack_req && !setup_match_evt);

  p_commit_needs_ack_pid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> rx_pid_vld && rx_pid[7:4] == ~rx_pid[3:0]);

endmodule

bind usb_addr_assign usb_addr_assign_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rx_pid_vld      (rx_pid_vld),
  .rx_pid          (rx_pid),
  .rx_tok_vld      (rx_tok_vld),
  .rx_tok_addr     (rx_tok_addr),
  .rx_eop          (rx_eop),
  .rx_crc_ok       (rx_crc_ok),
  .dev_addr        (dev_addr),
  .addr_valid      (addr_valid),
  .ack_req         (ack_req),
  .status_req      (status_req),
  .setup_match_evt (setup_match_evt),
  .commit_evt      (commit_evt)
);

// File: tb/usb_addr_assign_tb.sv
module usb_addr_assign_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_pid_vld = 1'b0;
  logic [7:0] rx_pid = '0;
  logic       rx_tok_vld = 1'b0;
  logic [6:0] rx_tok_addr = '0;
  logic [3:0] rx_tok_endp = '0;
  logic       rx_byte_vld = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_eop = 1'b0;
  logic       rx_crc_ok = 1'b0;
  logic [6:0] dev_addr;
  logic       addr_valid, ack_req, status_req;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  usb_addr_assign u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_pid_vld(rx_pid_vld), .rx_pid(rx_pid),
    .rx_tok_vld(rx_tok_vld), .rx_tok_addr(rx_tok_addr), .rx_tok_endp(rx_tok_endp),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
    .rx_eop(rx_eop), .rx_crc_ok(rx_crc_ok),
    .dev_addr(dev_addr), .addr_valid(addr_valid),
    .ack_req(ack_req), .status_req(status_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_pid(input logic [7:0] p);
    @(negedge clk); rx_pid_vld = 1'b1; rx_pid = p;
    @(negedge clk); rx_pid_vld = 1'b0;
  endtask

  task automatic send_tok(input logic [6:0] a, input logic [3:0] e);
    @(negedge clk); rx_tok_vld = 1'b1; rx_tok_addr = a; rx_tok_endp = e;
    @(negedge clk); rx_tok_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_byte_vld = 1'b1; rx_byte = b;
    @(negedge clk); rx_byte_vld = 1'b0;
  endtask

  task automatic send_eop(input logic crc);
    @(negedge clk); rx_eop = 1'b1; rx_crc_ok = crc;
    @(negedge clk); rx_eop = 1'b0; rx_crc_ok = 1'b0;
  endtask

  // Setup transaction; returns ack_req seen in the cycle after rx_eop.
  task automatic setup_txn(input logic [7:0] spid, input logic [6:0] ta,
                           input logic [7:0] dpid, input logic [7:0] b0,
                           input logic [7:0] b1, input logic [7:0] b2,
                           input int n, input logic crc, output logic ack_seen);
    send_pid(spid);
    send_tok(ta, 4'd0);
    send_pid(dpid);
    for (int i = 0; i < n; i++)
      send_byte(i == 0 ? b0 : i == 1 ? b1 : i == 2 ? b2 : 8'h00);
    send_eop(crc);
    ack_seen = ack_req;
    @(negedge clk);
    check("R4 ack_req falls after one cycle", ack_req, 0);
  endtask

  // Status stage: IN to 0/0, then the host ACK.
  task automatic status_txn(output logic stat_seen);
    send_pid(8'h69);
    send_tok(7'd0, 4'd0);
    stat_seen = status_req;
    send_pid(8'hD2);
  endtask

  task automatic t_reset();
    check("R1 dev_addr", dev_addr, 0);
    check("R1 addr_valid", addr_valid, 0);
    check("R1 ack_req", ack_req, 0);
    check("R1 status_req", status_req, 0);
  endtask

  task automatic t_bad_pid_check();
    logic a, s;
    setup_txn(8'h0D, 7'd0, 8'hC3, 8'h00, 8'h05, 8'h11, 8, 1'b1, a);
    check("R2 bad SETUP check nibble, no ack", a, 0);
    setup_txn(8'h2D, 7'd0, 8'h03, 8'h00, 8'h05, 8'h11, 8, 1'b1, a);
    check("R2 bad DATA0 check nibble, no ack", a, 0);
    status_txn(s);
    check("R2 address unchanged", dev_addr, 0);
  endtask

  task automatic t_bad_length_crc();
    logic a, s;
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h00, 8'h05, 8'h12, 7, 1'b1, a);
    check("R5 seven bytes, no ack", a, 0);
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h00, 8'h05, 8'h12, 9, 1'b1, a);
    check("R5 nine bytes, no ack", a, 0);
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h00, 8'h05, 8'h12, 8, 1'b0, a);
    check("R5 bad CRC, no ack", a, 0);
    status_txn(s);
    check("R5 no status after bad data", s, 0);
    check("R5 address unchanged", dev_addr, 0);
  endtask

  task automatic t_other_request();
    logic a, s;
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h80, 8'h06, 8'h01, 8, 1'b1, a);
    check("R6 other request still ACKed", a, 1);
    status_txn(s);
    check("R6 other request gives no status", s, 0);
    check("R6 other request leaves address", dev_addr, 0);
  endtask

  task automatic t_wrong_target();
    logic a;
    setup_txn(8'h2D, 7'd3, 8'hC3, 8'h00, 8'h05, 8'h13, 8, 1'b1, a);
    check("R3 SETUP to address 3 ignored", a, 0);
  endtask

  task automatic t_data1();
    logic a;
    setup_txn(8'h2D, 7'd0, 8'h4B, 8'h00, 8'h05, 8'h14, 8, 1'b1, a);
    check("R10 DATA1 stage not ACKed", a, 0);
  endtask

  task automatic t_enumerate(input logic [7:0] b2, input logic [6:0] exp_addr);
    logic a, s;
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h00, 8'h05, b2, 8, 1'b1, a);
    check("R4 good data stage ACKed", a, 1);
    check("R7 address held before status", dev_addr, 0);
    send_pid(8'h69);
    send_tok(7'd0, 4'd0);
    s = status_req;
    check("R7 status_req after IN token", s, 1);
    check("R7 address still 0 before host ACK", dev_addr, 0);
    send_pid(8'hD2);
    check("R8 address committed", dev_addr, exp_addr);
    check("R8 addr_valid", addr_valid, exp_addr != 0);
  endtask

  task automatic t_addressed_ignores(input logic [6:0] held);
    logic a, s;
    setup_txn(8'h2D, 7'd0, 8'hC3, 8'h00, 8'h05, 8'h09, 8, 1'b1, a);
    check("R9 no ack once addressed", a, 0);
    status_txn(s);
    check("R9 address kept", dev_addr, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_bad_pid_check();
    t_bad_length_crc();
    t_other_request();
    t_wrong_target();
    t_data1();
    t_enumerate(8'h2A, 7'h2A);
    t_addressed_ignores(7'h2A);
    do_reset();
    t_reset();
    t_enumerate(8'hC5, 7'h45);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule